// File: doc/BRIEF.md
# Binary to Canonic Signed-Digit Recoder

This block rewrites a fixed-point binary constant as a canonic signed-digit (CSD) vector. Each digit is +1, 0 or -1. The form is built so that no two neighbouring digits are both nonzero, which gives the fewest nonzero digits any signed-digit form of that value can have. A multiplier-free constant multiplier needs one shifted add or subtract per nonzero digit, so this vector is the schedule for that datapath. The input word is read as two's complement or as unsigned, chosen by a parameter.

A second stage can bound the number of shift-add terms. It keeps only the most significant nonzero digits, up to a limit supplied at the input, and clears every digit below them. The block returns three things: the digit vector, the count of nonzero digits that survive, and the signed value rebuilt from those digits. The rebuilt value lets the caller measure the error that truncation causes. The outputs are registered once by default. A parameter selects a purely combinational variant.

Top module: `csd_convert`

## Requirements
- R1: The output holds W+1 digits. Digit i occupies bits [2i+1:2i] of `digits_o` and is coded 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears.
- R2: No two adjacent digits of `digits_o` are both nonzero.
- R3: When `limit_i` is W+1 or more, `value_o` equals the input value exactly.
- R4: Without truncation, the digit vector is the unique nonadjacent signed-digit form of the input, so its nonzero count is the minimum possible.
- R5: With truncation, the nonzero digits that survive are the `limit_i` most significant nonzero digits of the full form, unchanged. All lower digits are zero. A limit of 0 clears every digit.
- R6: `nz_cnt_o` equals the number of nonzero digits in `digits_o` and never exceeds `limit_i`.
- R7: `value_o` is the sum of each output digit times 2^i, taken over the truncated digits, as a signed W+2 bit number.
- R8: An all-zero input gives an all-zero digit vector, a count of 0 and a value of 0, for any limit.
- R9: With the output register enabled, the outputs reflect the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are zero.
- R10: With SIGNED_IN=0, the input is read as unsigned. For example, 8'hFF is coded as +2^8 and -2^0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_i | input | W | Binary constant to recode |
| limit_i | input | $clog2(W+2) | Largest number of nonzero digits to keep |
| digits_o | output | 2*(W+1) | Signed-digit vector, two bits per digit |
| nz_cnt_o | output | $clog2(W+2) | Count of nonzero digits in `digits_o` |
| value_o | output | W+2 | Signed value rebuilt from `digits_o` |

## Verification
The bench sweeps every 8-bit input against every limit from 0 to 9, in both signed and unsigned modes. It computes the expected form with a shift-and-xor identity rather than a carry chain.

Several corner cases get particular attention:
- Long runs of ones, such as 8'h7F and 8'hFF. A recoder that skipped the carry into the top digit would return a value off by a power of two.
- The most negative input. Wrong sign extension turns it into a positive digit.
- Alternating patterns, which test whether adjacent digits are collapsed.
- Limits of 0, of one less than the natural count, and above W. A truncator that counted from the wrong end would keep low-order digits and produce a large error in `value_o`.

// File: rtl/csd_pkg.sv
package csd_pkg;

   typedef enum logic [1:0] {
      DIG_ZERO = 2'b00,
      DIG_POS  = 2'b01,
      DIG_NEG  = 2'b11
   } csd_digit_e;

   // Bit 0 flags a nonzero digit, bit 1 its sign.
   function automatic logic digit_nz(input logic [1:0] d);
      return d[0];
   endfunction

   function automatic logic digit_neg(input logic [1:0] d);
      return d[1] & d[0];
   endfunction

   function automatic logic digit_illegal(input logic [1:0] d);
      return d[1] & ~d[0];
   endfunction

endpackage

// File: rtl/csd_recode.sv
module csd_recode
   import csd_pkg::*;
#(
   parameter int W         = 8,
   parameter int SIGNED_IN = 1,
   parameter int ND        = W + 1
) (
   input  logic [W-1:0]        bin_i,
   output logic [ND-1:0][1:0]  dig_o
);

   localparam int XW = ND + 1;

   logic [XW-1:0] ext;
   logic [ND:0]   carry;

   generate
      if (SIGNED_IN != 0) begin : g_sext
         assign ext = {{(XW-W){bin_i[W-1]}}, bin_i};
      end else begin : g_zext
         assign ext = {{(XW-W){1'b0}}, bin_i};
      end
   endgenerate

   assign carry[0] = 1'b0;

   // Each position emits ext+carry_in-2*carry_out; carry_out is the
   // majority of this bit, the next bit and carry_in, which forces a
   // zero digit above every nonzero one.
   generate
      for (genvar i = 0; i < ND; i++) begin : g_pos
         logic nz;
         assign carry[i+1] = (ext[i] & ext[i+1]) |
                             (ext[i] & carry[i]) |
                             (ext[i+1] & carry[i]);
         assign nz       = ext[i] ^ carry[i];
         assign dig_o[i] = nz ? (carry[i+1] ? DIG_NEG : DIG_POS) : DIG_ZERO;
      end
   endgenerate

   always_comb begin
      if (!$isunknown(bin_i)) begin
         for (int i = 0; i < ND - 1; i++) begin
            a_r2_recode_nonadjacent: assert (!(digit_nz(dig_o[i]) && digit_nz(dig_o[i+1])))
               else $error("R2: adjacent nonzero digits at %0d", i);
         end
      end
   end

endmodule

// File: rtl/csd_truncate.sv
module csd_truncate
   import csd_pkg::*;
#(
   parameter int ND       = 9,
   parameter int CNT_W    = 4,
   parameter int TRUNC_EN = 1
) (
   input  logic [ND-1:0][1:0] dig_i,
   input  logic [CNT_W-1:0]   limit_i,
   output logic [ND-1:0][1:0] dig_o,
   output logic [CNT_W-1:0]   cnt_o
);

   // run[i] counts the digits kept strictly above position i-1.
   logic [ND:0][CNT_W-1:0] run;

   assign run[ND] = '0;

   generate
      if (TRUNC_EN != 0) begin : g_trunc
         for (genvar i = ND - 1; i >= 0; i--) begin : g_keep
            logic keep;
            assign keep     = digit_nz(dig_i[i]) && (run[i+1] < limit_i);
            assign dig_o[i] = keep ? dig_i[i] : DIG_ZERO;
            assign run[i]   = run[i+1] + CNT_W'(keep);
         end
      end else begin : g_pass
         for (genvar i = ND - 1; i >= 0; i--) begin : g_cnt
            assign dig_o[i] = dig_i[i];
            assign run[i]   = run[i+1] + CNT_W'(digit_nz(dig_i[i]));
         end
      end
   endgenerate

   assign cnt_o = run[0];

   always_comb begin
      if (!$isunknown(dig_i) && !$isunknown(limit_i)) begin
         for (int i = 0; i < ND; i++) begin
            a_r5_kept_subset: assert (!digit_nz(dig_o[i]) || (dig_o[i] == dig_i[i]))
               else $error("R5: digit %0d altered by truncation", i);
         end
         if (TRUNC_EN != 0) begin
            a_r6_cnt_bound: assert (cnt_o <= limit_i)
               else $error("R6: count %0d above limit %0d", cnt_o, limit_i);
         end
      end
   end

endmodule

// File: rtl/csd_rebuild.sv
module csd_rebuild
   import csd_pkg::*;
#(
   parameter int ND = 9,
   parameter int VW = ND + 1
) (
   input  logic [ND-1:0][1:0]  dig_i,
   output logic signed [VW-1:0] value_o
);

   always_comb begin
      value_o = '0;
      for (int i = 0; i < ND; i++) begin
         if (digit_nz(dig_i[i])) begin
            if (digit_neg(dig_i[i])) value_o = value_o - (VW'(1) << i);
            else                     value_o = value_o + (VW'(1) << i);
         end
      end
   end

endmodule

// File: rtl/csd_convert.sv
module csd_convert
   import csd_pkg::*;
#(
   parameter int W         = 8,
   parameter int SIGNED_IN = 1,
   parameter int TRUNC_EN  = 1,
   parameter int OUT_REG   = 1,
   localparam int ND       = W + 1,
   localparam int CNT_W    = $clog2(ND + 1),
   localparam int VW       = W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      bin_i,
   input  logic [CNT_W-1:0]  limit_i,
   output logic [2*ND-1:0]   digits_o,
   output logic [CNT_W-1:0]  nz_cnt_o,
   output logic [VW-1:0]     value_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("csd_convert: W must be at least 2");
      end
      if (SIGNED_IN != 0 && SIGNED_IN != 1) begin : g_bad_signed
         $error("csd_convert: SIGNED_IN must be 0 or 1");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
         $error("csd_convert: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic [ND-1:0][1:0]   full_dig;
   logic [ND-1:0][1:0]   kept_dig;
   logic [CNT_W-1:0]     kept_cnt;
   logic signed [VW-1:0] kept_val;

   csd_recode #(.W(W), .SIGNED_IN(SIGNED_IN), .ND(ND)) u_recode (
      .bin_i (bin_i),
      .dig_o (full_dig)
   );

   csd_truncate #(.ND(ND), .CNT_W(CNT_W), .TRUNC_EN(TRUNC_EN)) u_trunc (
      .dig_i   (full_dig),
      .limit_i (limit_i),
      .dig_o   (kept_dig),
      .cnt_o   (kept_cnt)
   );

   csd_rebuild #(.ND(ND), .VW(VW)) u_rebuild (
      .dig_i   (kept_dig),
      .value_o (kept_val)
   );

   generate
      if (OUT_REG != 0) begin : g_oreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               digits_o <= '0;
               nz_cnt_o <= '0;
               value_o  <= '0;
            end else begin
               digits_o <= kept_dig;
               nz_cnt_o <= kept_cnt;
               value_o  <= kept_val;
            end
         end
      end else begin : g_ocomb
         assign digits_o = kept_dig;
         assign nz_cnt_o = kept_cnt;
         assign value_o  = kept_val;
      end
   endgenerate

   // ---------------- checks on the port-level outputs ----------------
   logic signed [VW-1:0] bin_ext;
   logic                 out_illegal;
   logic                 out_adjacent;
   logic                 primed_q;

   generate
      if (SIGNED_IN != 0) begin : g_chk_sext
         assign bin_ext = {{(VW-W){bin_i[W-1]}}, bin_i};
      end else begin : g_chk_zext
         assign bin_ext = {{(VW-W){1'b0}}, bin_i};
      end
   endgenerate

   always_comb begin
      out_illegal  = 1'b0;
      out_adjacent = 1'b0;
      for (int i = 0; i < ND; i++) begin
         if (digit_illegal(digits_o[2*i +: 2])) out_illegal = 1'b1;
      end
      for (int i = 0; i < ND - 1; i++) begin
         if (digits_o[2*i] && digits_o[2*i+2]) out_adjacent = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   a_r1_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
      !out_illegal)
      else $error("R1: reserved digit code on output");

   a_r2_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      !out_adjacent)
      else $error("R2: adjacent nonzero output digits");

   generate
      if (OUT_REG != 0) begin : g_reg_checks
         a_r3_exact_value: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && ($past(limit_i) >= CNT_W'(ND))) |-> ($signed(value_o) == $past(bin_ext)))
            else $error("R3: rebuilt value differs from input");

         a_r8_zero_input: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && ($past(bin_i) == '0)) |-> (digits_o == '0 && nz_cnt_o == '0 && value_o == '0))
            else $error("R8: zero input gave nonzero output");

         if (TRUNC_EN != 0) begin : g_lim_check
            a_r6_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
               primed_q |-> (nz_cnt_o <= $past(limit_i)))
               else $error("R6: count exceeds limit");
         end
      end
   endgenerate

endmodule

// File: tb/csd_convert_tb.sv
module csd_convert_tb;

   localparam int W     = 8;
   localparam int ND    = W + 1;
   localparam int CNT_W = $clog2(ND + 1);
   localparam int VW    = W + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [W-1:0]     bin;
   logic [CNT_W-1:0] lim;
   logic [2*ND-1:0]  dig_s, dig_u;
   logic [CNT_W-1:0] cnt_s, cnt_u;
   logic [VW-1:0]    val_s, val_u;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   csd_convert #(.W(W), .SIGNED_IN(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bin_i(bin), .limit_i(lim),
      .digits_o(dig_s), .nz_cnt_o(cnt_s), .value_o(val_s));

   csd_convert #(.W(W), .SIGNED_IN(0)) u_dut_uns (
      .clk(clk), .rst_n(rst_n), .bin_i(bin), .limit_i(lim),
      .digits_o(dig_u), .nz_cnt_o(cnt_u), .value_o(val_u));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Nonadjacent form via n + n/2 xor trick, then keep the top lim digits.
   task automatic expect_csd(input int n, input int l, output logic [2*ND-1:0] ed,
                             output int ecnt, output int eval);
      int h, t, c, p, m;
      h = n >>> 1;
      t = n + h;
      c = h ^ t;
      p = t & c;
      m = h & c;
      ed = '0; ecnt = 0; eval = 0;
      for (int i = ND - 1; i >= 0; i--) begin
         if ((p[i] || m[i]) && ecnt < l) begin
            ecnt++;
            if (p[i]) begin ed[2*i +: 2] = 2'b01; eval += (1 << i); end
            else      begin ed[2*i +: 2] = 2'b11; eval -= (1 << i); end
         end
      end
   endtask

   task automatic check_out(input string tag, input bit uns, input int n, input int l,
                            input logic [2*ND-1:0] d, input logic [CNT_W-1:0] c,
                            input logic [VW-1:0] v);
      logic [2*ND-1:0] ed;
      int ecnt, eval, aval;
      bit bad_code, adj;
      expect_csd(n, l, ed, ecnt, eval);
      aval = int'($signed(v));
      bad_code = 1'b0; adj = 1'b0;
      for (int i = 0; i < ND; i++) if (d[2*i+1] && !d[2*i]) bad_code = 1'b1;
      for (int i = 0; i < ND - 1; i++) if (d[2*i] && d[2*i+2]) adj = 1'b1;
      chk(!bad_code, "R1", {tag, " reserved code"}, longint'(d), 0);
      chk(!adj, "R2", {tag, " adjacent digits"}, longint'(d), 0);
      if (l >= ND) begin
         chk(d == ed, "R4", {tag, " full digit form"}, longint'(d), longint'(ed));
         chk(aval == n, uns ? "R10" : "R3", {tag, " exact value"}, aval, n);
      end else begin
         chk(d == ed, "R5", {tag, " truncated digits"}, longint'(d), longint'(ed));
      end
      chk(int'(c) == ecnt, "R6", {tag, " nonzero count"}, c, ecnt);
      chk(aval == eval, "R7", {tag, " rebuilt value"}, aval, eval);
      if (n == 0) chk(d == '0 && c == '0 && v == '0, "R8", {tag, " zero input"}, longint'(d), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bin = 8'hA5;
      lim = CNT_W'(4);
      repeat (3) @(negedge clk);
      // R9: outputs held at zero in reset
      chk(dig_s == '0 && cnt_s == '0 && val_s == '0, "R9", "reset state", longint'(dig_s), 0);
      rst_n = 1'b1;
      @(negedge clk);
      bin = 8'h7F;
      lim = CNT_W'(ND);
      #1;
      // R9: still shows 8'hA5 limited to 4 until the next rising edge
      check_out("latency hold", 1'b0, int'($signed(8'hA5)), 4, dig_s, cnt_s, val_s);
      @(negedge clk);
      chk(int'($signed(val_s)) == 127, "R9", "one-edge latency", int'($signed(val_s)), 127);
      // R10: unsigned 8'hFF -> +2^8 -2^0
      bin = 8'hFF;
      @(negedge clk);
      chk(dig_u == 18'b01_0000_0000_0000_0011, "R10", "unsigned 8'hFF form", longint'(dig_u),
          longint'(18'b01_0000_0000_0000_0011));
      for (int l = 0; l <= ND; l++) begin
         for (int v = 0; v < 256; v++) begin
            bin = W'(v);
            lim = CNT_W'(l);
            @(negedge clk);
            check_out("signed", 1'b0, int'($signed(W'(v))), l, dig_s, cnt_s, val_s);
            check_out("unsigned", 1'b1, v, l, dig_u, cnt_u, val_u);
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule